// File: doc/BRIEF.md
# Programmable Down-Counting Timer

This block is a single 32-bit down-counter with a small register file. Software reaches it over a plain synchronous bus: byte address, write data, a write strobe and a read strobe. Read data is combinational and comes back in the same cycle as the read strobe. One interrupt pin reports expiry. The bus is a register interface and has no back-pressure: every strobe is taken in the cycle it is presented. The counter advances only on prescaled ticks, so it is a control path and carries no valid/ready stream.

Software programs a reload value in one of two ways. The immediate path also forces the count. The background path changes only what the next reload uses. Software then picks a mode in the control word:

- one-shot: stop at zero
- periodic: reload from the programmed value
- free-running: reload from the all-ones value of the selected width, 16 or 32 bits

It also picks the prescale, enables counting and enables the interrupt. The interrupt flag is raised when the count steps from 1 to 0. Software reads the flag both raw and masked by the enable, and clears it by writing the clear register.

Top module: `dcnt_timer`

## Requirements
- R1: After reset the control word reads 0x20, the reload value and count read 0, the raw and masked status read 0, irq is low, and the counter does not move.
- R2: The word index is the byte address shifted right by 2. Index 0 and index 6 both read the stored reload value, index 1 reads the count, index 2 reads the control byte, index 4 reads the raw flag in bit 0, and index 5 reads the masked flag in bit 0. Index 3, indices above 6, any address with non-zero low two bits, and any cycle without the read strobe read 0. Writes to those unmapped places change nothing.
- R3: The control byte holds these fields: bit 0 one-shot, bit 1 32-bit width, bits 3:2 prescale code, bit 5 interrupt enable, bit 6 periodic, bit 7 run. Prescale code 1 gives a tick every 16 running clocks and code 2 every 256. Codes 0 and 3 give a tick every running clock. Any control write restarts the prescale count.
- R4: On each tick the count decrements by one. A tick that steps the count from 1 to 0 sets the raw flag.
- R5: With one-shot set, a tick at count 0 leaves the count at 0.
- R6: With periodic set and one-shot clear, a tick at count 0 reloads the stored reload value.
- R7: With both periodic and one-shot clear, a tick at count 0 reloads 0xFFFF in 16-bit mode and 0xFFFFFFFF in 32-bit mode.
- R8: A write to index 0 stores the reload value and sets the count to the written value in the next cycle. It takes priority over a tick in the same cycle, which then neither decrements nor expires.
- R9: A write to index 6 stores the reload value and leaves the count untouched. The new value is used at the next reload.
- R10: In 16-bit mode only the low 16 bits count and expire, and index 1 reads them zero-extended.
- R11: Writes to index 1 have no effect on the count.
- R12: irq equals raw flag AND interrupt enable. Masked status reads 0 while the enable is clear. Any write to index 3 clears the raw flag, but an expiry in the same cycle wins and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, same cycle as bus_re |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land in the same clock edge. An interrupt-clear write can meet the tick that steps the count from 1 to 0, and an immediate load can meet an ordinary tick. The bench finds each collision by watching its own reference count and issuing the write in the cycle before the edge on which the model knows a divide-by-one tick will fire. It then judges the outcome against the stated priorities: the flag stays set, and the count becomes the written value rather than one less.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  localparam int unsigned CNT_W  = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned NSLOT  = 7;

  typedef enum logic [2:0] {
    IDX_LOAD   = 3'd0,
    IDX_VALUE  = 3'd1,
    IDX_CTRL   = 3'd2,
    IDX_ICLR   = 3'd3,
    IDX_RAW    = 3'd4,
    IDX_MASK   = 3'd5,
    IDX_BGLOAD = 3'd6
  } word_idx_e;

  typedef struct packed {
    logic       run;
    logic       periodic;
    logic       ie;
    logic       spare;
    logic [1:0] pre;
    logic       wide;
    logic       oneshot;
  } ctrl_t;

  localparam logic [7:0] CTRL_RESET = 8'h20;
endpackage

// File: rtl/dcnt_prescale.sv
module dcnt_prescale #(
  parameter int unsigned MID_LOG = 4,
  parameter int unsigned HI_LOG  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] code,
  input  logic       restart,
  output logic       tick
);
  localparam int unsigned PRE_W = HI_LOG;
  localparam logic [PRE_W-1:0] LIM_MID = PRE_W'((1 << MID_LOG) - 1);
  localparam logic [PRE_W-1:0] LIM_HI  = PRE_W'((1 << HI_LOG) - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  always_comb begin
    case (code)
      2'd1:    lim = LIM_MID;
      2'd2:    lim = LIM_HI;
      default: lim = '0;
    endcase
  end

  assign tick = run && (pre_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)                  pre_q <= '0;
    else if (restart || !run)    pre_q <= '0;
    else if (tick)               pre_q <= '0;
    else                         pre_q <= pre_q + 1'b1;
  end

  // R3: with a divided prescale, two ticks never come back to back
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && (code == 2'd1 || code == 2'd2)) |=> !tick);
endmodule

// File: rtl/dcnt_core.sv
module dcnt_core
  import dcnt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             oneshot,
  input  logic             periodic,
  input  logic             wide,
  input  logic             ld_now,
  input  logic             ld_bg,
  input  logic             clr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] value,
  output logic [CNT_W-1:0] reload,
  output logic             raw
);
  localparam logic [CNT_W-1:0] MAX16 = CNT_W'({HALF_W{1'b1}});
  localparam logic [CNT_W-1:0] MAX32 = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, reload_q, max_val;
  logic             raw_q, expire;

  assign max_val = wide ? MAX32 : MAX16;
  assign value   = wide ? cnt_q : {{(CNT_W-HALF_W){1'b0}}, cnt_q[HALF_W-1:0]};
  assign expire  = tick && !ld_now && (value == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (ld_now)
      cnt_d = wdata;
    else if (tick) begin
      if (value != '0)   cnt_d = value - 1'b1;
      else if (oneshot)  cnt_d = cnt_q;
      else if (periodic) cnt_d = reload_q;
      else               cnt_d = max_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
      raw_q    <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (ld_now || ld_bg) reload_q <= wdata;
      if (expire)          raw_q <= 1'b1;
      else if (clr)        raw_q <= 1'b0;
    end
  end

  assign reload = reload_q;
  assign raw    = raw_q;

  assert_expire_sets_raw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_now && value == CNT_W'(1)) |=> raw);
  assert_oneshot_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_now && oneshot && value == '0) |=> (value == '0));
  assert_periodic_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_now && !oneshot && periodic && value == '0) |=> (cnt_q == $past(reload_q)));
  assert_free_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_now && !oneshot && !periodic && value == '0) |=> (cnt_q == $past(max_val)));
  assert_load_forces_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_now |=> (cnt_q == $past(wdata)));
  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_now) |=> $stable(cnt_q));
  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(tick && !ld_now && value == CNT_W'(1))) |=> !raw);
endmodule

// File: rtl/dcnt_regs.sv
module dcnt_regs
  import dcnt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  input  logic [7:0]        wbyte,
  input  logic [CNT_W-1:0]  value,
  input  logic [CNT_W-1:0]  reload,
  input  logic              raw,
  output ctrl_t             ctrl,
  output logic              ctrl_wr,
  output logic              ld_now,
  output logic              ld_bg,
  output logic              clr,
  output logic [CNT_W-1:0]  rdata
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic             aligned;
  logic [NSLOT-1:0] hit;
  ctrl_t            ctrl_q;

  assign widx    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign hit[g] = aligned && (widx == IDX_W'(g));
  end

  assign ctrl_wr = we && hit[IDX_CTRL];
  assign ld_now  = we && hit[IDX_LOAD];
  assign ld_bg   = we && hit[IDX_BGLOAD];
  assign clr     = we && hit[IDX_ICLR];

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= ctrl_t'(CTRL_RESET);
    else if (ctrl_wr) ctrl_q <= ctrl_t'(wbyte);
  end
  assign ctrl = ctrl_q;

  always_comb begin
    rdata = '0;
    if (re) begin
      if (hit[IDX_LOAD] || hit[IDX_BGLOAD]) rdata = reload;
      else if (hit[IDX_VALUE])              rdata = value;
      else if (hit[IDX_CTRL])               rdata = CNT_W'(ctrl_q);
      else if (hit[IDX_RAW])                rdata = CNT_W'(raw);
      else if (hit[IDX_MASK])               rdata = CNT_W'(raw && ctrl_q.ie);
    end
  end

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_wr, ld_now, ld_bg, clr}));
  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (re && (hit == '0 || hit[IDX_ICLR])) |-> (rdata == '0));
  assert_masked_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (re && hit[IDX_MASK] && !ctrl_q.ie) |-> (rdata == '0));
endmodule

// File: rtl/dcnt_timer.sv
module dcnt_timer
  import dcnt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned MID_LOG = 4,
  parameter int unsigned HI_LOG  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  ctrl_t            ctrl;
  logic             ctrl_wr, ld_now, ld_bg, clr, tick, raw;
  logic [CNT_W-1:0] value, reload;

  dcnt_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .re(bus_re),
    .wbyte(bus_wdata[7:0]), .value(value), .reload(reload), .raw(raw),
    .ctrl(ctrl), .ctrl_wr(ctrl_wr), .ld_now(ld_now), .ld_bg(ld_bg),
    .clr(clr), .rdata(bus_rdata)
  );

  dcnt_prescale #(.MID_LOG(MID_LOG), .HI_LOG(HI_LOG)) pre_i (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .code(ctrl.pre),
    .restart(ctrl_wr), .tick(tick)
  );

  dcnt_core core_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .oneshot(ctrl.oneshot),
    .periodic(ctrl.periodic), .wide(ctrl.wide), .ld_now(ld_now),
    .ld_bg(ld_bg), .clr(clr), .wdata(bus_wdata), .value(value),
    .reload(reload), .raw(raw)
  );

  assign irq = raw && ctrl.ie;

  assert_irq_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.ie) |-> !irq);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    (!rst_n) |=> (!irq && value == '0));
endmodule

// File: tb/dcnt_timer_tb_top.sv
module dcnt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dcnt_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference model
  logic [7:0]  m_ctrl = 8'h20;
  logic [31:0] m_load = 0;
  logic [31:0] m_cnt  = 0;
  logic        m_raw  = 0;
  int          m_pre  = 0;

  function automatic logic [31:0] m_eff();
    return m_ctrl[1] ? m_cnt : {16'h0, m_cnt[15:0]};
  endfunction

  function automatic logic [31:0] m_read(int idx);
    case (idx)
      0, 6:    return m_load;
      1:       return m_eff();
      2:       return {24'h0, m_ctrl};
      4:       return {31'h0, m_raw};
      5:       return {31'h0, m_raw & m_ctrl[5]};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 8'h20; m_load = 0; m_cnt = 0; m_raw = 0; m_pre = 0;
    end else begin
      bit ok, w_ld, w_bg, w_ctl, w_clr, tk, exp_now;
      int idx, div;
      logic [31:0] nc, eff;
      ok    = (bus_addr[1:0] == 0);
      idx   = int'(bus_addr >> 2);
      w_ld  = bus_we && ok && idx == 0;
      w_ctl = bus_we && ok && idx == 2;
      w_clr = bus_we && ok && idx == 3;
      w_bg  = bus_we && ok && idx == 6;
      div   = (m_ctrl[3:2] == 1) ? 16 : (m_ctrl[3:2] == 2) ? 256 : 1;
      tk    = m_ctrl[7] && (m_pre == div - 1);
      eff   = m_eff();
      nc    = m_cnt;
      exp_now = 0;
      if (w_ld) nc = bus_wdata;
      else if (tk) begin
        if (eff != 0) begin nc = eff - 1; exp_now = (eff == 1); end
        else if (m_ctrl[0]) nc = m_cnt;
        else if (m_ctrl[6]) nc = m_load;
        else nc = m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      end
      if (w_ctl || !m_ctrl[7] || tk) m_pre = 0; else m_pre = m_pre + 1;
      if (exp_now) m_raw = 1; else if (w_clr) m_raw = 0;
      if (w_ld || w_bg) m_load = bus_wdata;
      if (w_ctl) m_ctrl = bus_wdata[7:0];
      m_cnt = nc;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk("R12 irq", {31'h0, irq}, {31'h0, m_raw & m_ctrl[5]});
  endtask

  task automatic wr(int idx, logic [31:0] v);
    bus_we = 1; bus_addr = 12'(idx * 4); bus_wdata = v;
    step();
    bus_we = 0;
  endtask

  task automatic rd(int idx, string tag);
    bus_re = 1; bus_addr = 12'(idx * 4);
    #1;
    chk(tag, bus_rdata, m_read(idx));
    bus_re = 0;
  endtask

  task automatic rd_lit(int idx, string tag, logic [31:0] exp);
    bus_re = 1; bus_addr = 12'(idx * 4);
    #1;
    chk(tag, bus_rdata, exp);
    bus_re = 0;
  endtask

  task automatic watch(int n, string tag);
    for (int i = 0; i < n; i++) begin
      rd(1, tag);
      step();
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd_lit(2, "R1 ctrl", 32'h20);
    rd_lit(0, "R1 load", 0);
    rd_lit(1, "R1 value", 0);
    rd_lit(4, "R1 raw", 0);
    rd_lit(5, "R1 masked", 0);
    chk("R1 irq", {31'h0, irq}, 0);
    watch(4, "R1 stopped");
    // R2 unmapped and misaligned reads, writes ignored
    rd_lit(3, "R2 clear reads 0", 0);
    rd_lit(7, "R2 idx7", 0);
    rd_lit(200, "R2 far", 0);
    bus_re = 1; bus_addr = 12'h001; #1;
    chk("R2 misaligned", bus_rdata, 0); bus_re = 0;
    bus_we = 1; bus_addr = 12'h001; bus_wdata = 32'h55; step(); bus_we = 0;
    rd_lit(0, "R2 misaligned write ignored", 0);
    wr(9, 32'hFF);
    rd_lit(2, "R2 unmapped write ignored", 32'h20);

    // R4 R6 periodic 32-bit div1
    wr(0, 5);
    rd_lit(1, "R8 load forces", 5);
    wr(2, 32'hE2);
    watch(14, "R6 periodic");
    rd_lit(4, "R4 raw set", 1);
    wr(3, 0);
    rd_lit(4, "R12 cleared", 0);

    // R8 load collides with tick
    watch(2, "R4 run");
    wr(0, 32'h40);
    rd_lit(1, "R8 load wins over tick", 32'h40);
    watch(3, "R8 after");

    // R12 clear collides with expiry
    wr(3, 0);
    wr(0, 6);
    while (m_eff() != 1) begin rd(1, "R12 approach"); step(); end
    wr(3, 0);
    rd_lit(4, "R12 expiry beats clear", 1);
    wr(3, 0);
    rd_lit(4, "R12 clear", 0);

    // R9 background load
    wr(0, 10);
    watch(3, "R9 before");
    wr(6, 3);
    rd_lit(0, "R9 load reads new", 3);
    rd_lit(6, "R9 bg reads new", 3);
    rd_lit(1, "R9 count undisturbed", 6);
    watch(12, "R9 reload uses new");

    // R5 one-shot
    wr(2, 32'h23);
    wr(0, 3);
    wr(2, 32'hA3);
    watch(8, "R5 oneshot");
    rd_lit(1, "R5 stays zero", 0);
    rd_lit(4, "R5 raw", 1);
    wr(3, 0);

    // R7 free running 16-bit and 32-bit
    wr(2, 32'h20);
    wr(0, 32'h12345);
    rd_lit(1, "R10 zero-extended", 32'h2345);
    wr(0, 2);
    wr(2, 32'hA0);
    watch(3, "R7 free16");
    rd_lit(1, "R7 max16", 32'hFFFF);
    watch(3, "R7 free16 run");
    wr(2, 32'h22);
    wr(0, 1);
    wr(2, 32'hA2);
    watch(2, "R7 free32");
    rd_lit(1, "R7 max32", 32'hFFFF_FFFF);

    // R10 16-bit expiry on low half with high bits set
    wr(2, 32'h20);
    wr(0, 32'h7_0003);
    wr(3, 0);
    wr(2, 32'hE0);
    watch(6, "R10 low half");

    // R11 value writes ignored
    wr(2, 32'h22);
    wr(0, 32'h77);
    wr(1, 32'h1234);
    rd_lit(1, "R11 value write ignored", 32'h77);

    // R3 prescale
    wr(2, 32'hE6);
    watch(60, "R3 div16");
    wr(2, 32'hEA);
    watch(600, "R3 div256");
    wr(2, 32'hEE);
    watch(8, "R3 code3");

    // R12 enable off masks irq
    wr(0, 2);
    wr(2, 32'hC2);
    watch(4, "R12 masked run");
    rd_lit(4, "R12 raw with ie off", 1);
    rd_lit(5, "R12 masked zero", 0);
    chk("R12 irq low", {31'h0, irq}, 0);
    wr(2, 32'hE2);
    chk("R12 irq high", {31'h0, irq}, 1);

    finish_run();
  end
endmodule